// File: doc/BRIEF.md
# Receive Baseband Offset Calibration Sequencer

This block drives a successive-approximation search that trims the DC offset of two receive baseband channels, in-phase (I) and quadrature (Q). It runs on the reference clock and divides that clock by a programmable 7-bit value C. A further division by two gives the slot clock, so each slot lasts 2*C reference cycles. A rising edge on an asynchronous calibration request input starts a fixed timeline of 22 slots. The first slots let the analog chain settle and then auto-zero the offset comparators. A window of search slots then decides one correction bit per slot for each channel. In the final slot both codes are frozen until the next request edge.

Each channel has a one-bit comparator input. It reports whether the residual offset left by the current trial code is positive, which means the trial code is too large. The two channels are searched in parallel but decide their bits independently. Phase strobes (settle, comparator auto-zero, hold) and a busy flag let the surrounding analog logic sequence itself. An AGC-off output mutes the receive amplifiers while a cycle runs in receive mode.

Top module: `offcal_sequencer`

## Requirements
- R1: After reset both correction codes are 8'h80, and busy, settle, auto-zero, AGC-off and hold are all low.
- R2: The request input passes through a two-flop synchronizer and its rising edge is detected. Slot 1 begins at the next boundary of the divide-by-C counter, which is between 3 and C+3 reference cycles after the request rises.
- R3: Every slot lasts 2*C reference cycles, with C taken from the 7-bit divide input (a value of 0 acts as 1). Busy is high from the start of slot 1 until slot 22 is entered, which is exactly 42*C cycles.
- R4: Settle is high during slots 1 to 7, which is 14*C cycles from the first busy cycle. Auto-zero is high during slots 8 to 10, which is 6*C cycles directly after settle. Slots 11 and 12 and the search slots assert neither.
- R5: On entry to slot 13 a channel's code becomes 8'h80. At the end of each slot from 13 to 20 the bit under trial (bit 7 in slot 13, down to bit 0 in slot 20) is cleared if that channel's comparator input is 1 and kept if it is 0. The next lower bit is then set for trial. Slot 21 changes nothing. With a comparator that reports (code > target), the final code equals the target for every target from 0 to 255.
- R6: The I and Q channels search independently, each using only its own comparator input.
- R7: From slot 22 on, hold is high and busy is low, and both codes stay unchanged whatever the comparator inputs do, until a new request edge starts another cycle.
- R8: AGC-off equals busy while the receive-mode input is 1 and stays low while it is 0.
- R9: A request rising edge during an active cycle restarts the timeline at slot 1 on the next divider boundary. Busy stays high without a gap, settle asserts again, and a full search follows.
- R10: A request input that is held high starts no further cycle. Only a new low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| div_c | input | 7 | Divide value C; one slot lasts 2*C reference cycles |
| cal_req | input | 1 | Asynchronous calibration request; a rising edge starts a cycle |
| rx_mode | input | 1 | 1 when the receiver is active, so AGC-off follows busy |
| cmp_i | input | 1 | I comparator: 1 = residual positive, trial code too large |
| cmp_q | input | 1 | Q comparator: 1 = residual positive, trial code too large |
| code_i | output | 8 | I-channel offset correction code |
| code_q | output | 8 | Q-channel offset correction code |
| busy | output | 1 | High during slots 1 to 21 |
| settle | output | 1 | High during slots 1 to 7 |
| autozero | output | 1 | High during slots 8 to 10 (comparator auto-balance) |
| agc_off | output | 1 | Mutes the receive AGC during a cycle in receive mode |
| hold | output | 1 | High in slot 22 while the codes are frozen |

## Verification
The assertions check on every cycle that the relations between the phase outputs hold. At most one of settle, auto-zero and hold is high, and busy never overlaps hold. A cycle always begins in settle and ends in hold, auto-zero only follows settle, and AGC-off never appears outside busy in receive mode. Codes never move while the block is idle or holding. The exact slot lengths for several values of C, the latency from the request edge, and the numeric result of the binary search are shown only by the bench's scenarios. The bench sweeps every I target and pairs it with a different Q target, adds mid-cycle restarts, holds the request level high, and changes the comparator inputs during hold.

// File: rtl/offcal_pkg.sv
package offcal_pkg;
  localparam int SLOT_W = 5;
  typedef logic [SLOT_W-1:0] slot_t;

  localparam slot_t SLOT_IDLE       = 5'd0;
  localparam slot_t SLOT_SETTLE_LO  = 5'd1;
  localparam slot_t SLOT_SETTLE_HI  = 5'd7;
  localparam slot_t SLOT_AZ_LO      = 5'd8;
  localparam slot_t SLOT_AZ_HI      = 5'd10;
  localparam slot_t SLOT_SRCH_LO    = 5'd13;
  localparam slot_t SLOT_SRCH_HI    = 5'd21;
  localparam slot_t SLOT_STORE      = 5'd22;
endpackage

// File: rtl/offcal_edge_sync.sv
module offcal_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;
endmodule

// File: rtl/offcal_divider.sv
module offcal_divider #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = (div_val == '0) ? '0 : div_val - 1'b1;
    tick  = (cnt_q >= limit);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/offcal_sar_chan.sv
module offcal_sar_chan #(
  parameter int CODE_W = 8,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [POS_W-1:0]  pos,
  input  logic              cmp_hi,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code_q, code_d, trial_bit, next_bit;
  logic              code_en;

  always_comb begin
    trial_bit = MIDSCALE >> pos;
    next_bit  = trial_bit >> 1;
    code_en   = load | step;
    code_d    = code_q;
    if (load)      code_d = MIDSCALE;
    else if (step) code_d = (cmp_hi ? (code_q & ~trial_bit) : code_q) | next_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= MIDSCALE;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/offcal_sequencer.sv
module offcal_sequencer
  import offcal_pkg::*;
#(
  parameter int DIV_W  = 7,
  parameter int CODE_W = 8
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_c,
  input  logic              cal_req,
  input  logic              rx_mode,
  input  logic              cmp_i,
  input  logic              cmp_q,
  output logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_q,
  output logic              busy,
  output logic              settle,
  output logic              autozero,
  output logic              agc_off,
  output logic              hold
);
  localparam int    NCH        = 2;
  localparam slot_t SRCH_LAST  = SLOT_SRCH_LO + slot_t'(CODE_W - 1);

  logic  rise, half_tick;
  slot_t slot_q, slot_d;
  logic  phase_q, phase_d, pend_q, pend_d;
  logic  active, start_go, advance, sar_load, sar_step;
  slot_t srch_pos;
  logic [NCH-1:0]    cmp_vec;
  logic [CODE_W-1:0] code_vec [NCH];

  offcal_edge_sync u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .async_in (cal_req),
    .rise     (rise)
  );

  offcal_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .div_val (div_c),
    .tick    (half_tick)
  );

  always_comb begin
    active   = (slot_q >= SLOT_SETTLE_LO) && (slot_q <= SLOT_SRCH_HI);
    start_go = half_tick && (pend_q || rise);
    advance  = half_tick && !start_go && active && phase_q;
    slot_d   = slot_q;
    phase_d  = phase_q;
    pend_d   = pend_q || rise;
    if (start_go) begin
      slot_d  = SLOT_SETTLE_LO;
      phase_d = 1'b0;
      pend_d  = 1'b0;
    end else if (half_tick && active) begin
      if (phase_q) begin
        slot_d  = slot_q + 1'b1;
        phase_d = 1'b0;
      end else begin
        phase_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SLOT_IDLE;
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      phase_q <= phase_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    srch_pos = slot_q - SLOT_SRCH_LO;
    sar_load = advance && (slot_q == SLOT_SRCH_LO - 1'b1);
    sar_step = advance && (slot_q >= SLOT_SRCH_LO) && (slot_q <= SRCH_LAST);
  end

  assign cmp_vec = {cmp_q, cmp_i};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    offcal_sar_chan #(.CODE_W(CODE_W), .POS_W(SLOT_W)) u_sar (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .load   (sar_load),
      .step   (sar_step),
      .pos    (srch_pos),
      .cmp_hi (cmp_vec[ch]),
      .code   (code_vec[ch])
    );
  end

  assign code_i   = code_vec[0];
  assign code_q   = code_vec[1];
  assign busy     = active;
  assign settle   = (slot_q >= SLOT_SETTLE_LO) && (slot_q <= SLOT_SETTLE_HI);
  assign autozero = (slot_q >= SLOT_AZ_LO) && (slot_q <= SLOT_AZ_HI);
  assign hold     = (slot_q == SLOT_STORE);
  assign agc_off  = active && rx_mode;
endmodule

// File: rtl/offcal_checker.sv
module offcal_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic              rx_mode,
  input logic [CODE_W-1:0] code_i,
  input logic [CODE_W-1:0] code_q,
  input logic              busy,
  input logic              settle,
  input logic              autozero,
  input logic              agc_off,
  input logic              hold
);
  assert_phase_onehot_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $onehot0({settle, autozero, hold}));

  assert_autozero_after_settle_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(autozero) |-> $past(settle));

  assert_busy_not_hold_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(busy && hold));

  assert_start_in_settle_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(busy) |-> settle);

  assert_end_in_hold_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(busy) |-> hold);

  assert_codes_frozen_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(code_i) && $stable(code_q)));

  assert_agc_in_cycle_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    agc_off |-> (busy && rx_mode));
endmodule

bind offcal_sequencer offcal_checker #(.CODE_W(CODE_W)) u_offcal_chk (
  .clk_ref  (clk_ref),
  .rst_n    (rst_n),
  .rx_mode  (rx_mode),
  .code_i   (code_i),
  .code_q   (code_q),
  .busy     (busy),
  .settle   (settle),
  .autozero (autozero),
  .agc_off  (agc_off),
  .hold     (hold)
);

// File: tb/sim_offcal_sequencer.sv
module sim_offcal_sequencer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] div_c;
  logic       cal_req, rx_mode;
  logic [7:0] tgt_i, tgt_q;
  logic       cmp_i, cmp_q;
  logic [7:0] code_i, code_q;
  logic       busy, settle, autozero, agc_off, hold;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  assign cmp_i = (code_i > tgt_i);
  assign cmp_q = (code_q > tgt_q);

  offcal_sequencer u0 (
    .clk_ref (clk), .rst_n (rst_n), .div_c (div_c), .cal_req (cal_req),
    .rx_mode (rx_mode), .cmp_i (cmp_i), .cmp_q (cmp_q),
    .code_i (code_i), .code_q (code_q), .busy (busy), .settle (settle),
    .autozero (autozero), .agc_off (agc_off), .hold (hold)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
  end

  // Raise the request, then measure start latency and phase lengths.
  task automatic run_cycle(input int c, input logic [7:0] ti, input logic [7:0] tq,
                           input logic rx, input bit full);
    int k, nb, ns, na, nagc;
    int eff;
    eff = (c == 0) ? 1 : c;
    @(negedge clk);
    div_c = 7'(c); tgt_i = ti; tgt_q = tq; rx_mode = rx;
    cal_req = 1'b1;
    k = 0;
    while (!busy && k < eff + 10) begin
      @(negedge clk);
      k++;
    end
    if (full) check(k >= 3 && k <= eff + 3, "R2 start latency", k, eff + 3);
    nb = 0; ns = 0; na = 0; nagc = 0;
    while (busy && nb < 100 * eff + 100) begin
      nb++;
      if (settle) ns++;
      if (autozero && ns == 14 * eff) na++;
      if (agc_off == (busy && rx)) nagc++;
      @(negedge clk);
    end
    cal_req = 1'b0;
    if (full) begin
      check(nb == 42 * eff, "R3 busy length", nb, 42 * eff);
      check(ns == 14 * eff, "R4 settle length", ns, 14 * eff);
      check(na == 6 * eff, "R4 autozero length", na, 6 * eff);
      check(nagc == nb, "R8 agc_off follows busy", nagc, nb);
    end
    check(hold && !busy, "R7 hold after cycle", int'(hold), 1);
    check(code_i == ti, "R5 I search result", int'(code_i), int'(ti));
    check(code_q == tq, "R6 Q search result", int'(code_q), int'(tq));
  endtask

  initial begin
    rst_n = 1'b0; div_c = 7'd1; cal_req = 1'b0; rx_mode = 1'b0;
    tgt_i = 8'd0; tgt_q = 8'd0;
    repeat (4) @(negedge clk);
    check(code_i == 8'h80 && code_q == 8'h80, "R1 reset codes", int'(code_i), 128);
    check(!busy && !settle && !autozero && !agc_off && !hold, "R1 reset strobes",
          int'({busy, settle, autozero, agc_off, hold}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !hold, "R1 idle after reset", int'(busy), 0);

    // Full sweep of I targets with C=1, Q target scrambled.
    for (int t = 0; t < 256; t++) begin
      run_cycle(1, 8'(t), 8'((t * 97 + 13) & 255), t[0], (t % 16) == 0);
      repeat (3) @(negedge clk);
    end

    // Several divide values.
    run_cycle(2, 8'd200, 8'd3, 1'b1, 1'b1);   repeat (3) @(negedge clk);
    run_cycle(3, 8'd255, 8'd0, 1'b0, 1'b1);   repeat (3) @(negedge clk);
    run_cycle(7, 8'd1, 8'd254, 1'b1, 1'b1);   repeat (3) @(negedge clk);
    run_cycle(0, 8'd77, 8'd128, 1'b1, 1'b1);  repeat (3) @(negedge clk);
    run_cycle(127, 8'd127, 8'd129, 1'b1, 1'b1); repeat (3) @(negedge clk);

    // R7: comparators change during hold; codes must stay.
    begin
      logic [7:0] ki, kq;
      ki = code_i; kq = code_q;
      tgt_i = ~tgt_i; tgt_q = 8'd0;
      repeat (200) @(negedge clk);
      check(code_i == ki && code_q == kq, "R7 codes held", int'(code_i), int'(ki));
      check(hold && !busy, "R7 still holding", int'(hold), 1);
    end

    // R10: request held high starts no further cycle.
    begin
      int seen;
      @(negedge clk);
      div_c = 7'd2; cal_req = 1'b1;
      while (!busy) @(negedge clk);
      while (busy) @(negedge clk);
      seen = 0;
      repeat (300) begin
        @(negedge clk);
        if (busy) seen++;
      end
      check(seen == 0, "R10 level does not retrigger", seen, 0);
      cal_req = 1'b0;
      repeat (5) @(negedge clk);
    end

    // R9: restart during the search window.
    begin
      int n, gap, resettle;
      @(negedge clk);
      div_c = 7'd4; tgt_i = 8'd45; tgt_q = 8'd210; rx_mode = 1'b1;
      cal_req = 1'b1;
      while (!busy) @(negedge clk);
      repeat (8) @(negedge clk);
      cal_req = 1'b0;
      n = 0;
      while (n < 8 * 15) begin
        @(negedge clk);
        n++;
      end
      cal_req = 1'b1;
      gap = 0; resettle = 0;
      repeat (50) begin
        @(negedge clk);
        if (!busy) gap++;
        if (settle) resettle++;
      end
      check(gap == 0, "R9 busy continuous on restart", gap, 0);
      check(resettle > 0, "R9 settle reasserted", resettle, 1);
      n = 0;
      while (busy && n < 2000) begin
        @(negedge clk);
        n++;
      end
      check(hold, "R9 restart ends in hold", int'(hold), 1);
      check(code_i == 8'd45 && code_q == 8'd210, "R9 restart result",
            int'(code_i), 45);
      cal_req = 1'b0;
    end

    done = 1'b1;
    summary();
  end
endmodule